// File: doc/BRIEF.md
# Serial PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial link PHY from cold to usable by driving a simple command port: a master beneath it turns each request into the PHY's capture and acknowledge handshake and reports done or failure. When enable rises, the sequencer applies the static configuration. It raises the PLL clock enable one cycle later, as a separate step, and then waits a programmable pre-access delay. It then issues the fixed bring-up chain: select the clock/reset register, write its reset bit, and poll the lane status register until the receive-PLL state bit reads high. Once lock is seen, a settling delay runs before ready is raised.

Polling is bounded. Each attempt is preceded by its own wait, and after a set number of reads without lock the block stops and reports a lock timeout. A failure reported by the command master ends the sequence at once, with its own error code. A power-down request drops the PLL clock enable and sets the PHY's low-power test bit. That state is final: only a reset leaves it, and enable is ignored until then. Every delay is a parameter in clock cycles, so a short setting can be used in simulation.

Top module: `phy_pll_bringup`

## Requirements
- R1: After reset, ready, error, err_code, cfg_en, pll_clk_en, pddq and cmd_req are all 0.
- R2: Enable high in idle sets cfg_en on the next cycle, and pll_clk_en follows exactly one cycle after cfg_en; pll_clk_en is never 1 while cfg_en is 0.
- R3: The first command rises PRE_WAIT_CYC cycles after pll_clk_en rises. It is op 0 (address) with data 0x7F3F, followed immediately after its completion by op 1 (write) with data 0x0001. Op codes: 0 address, 1 write, 2 read.
- R4: Only one command is outstanding at a time: cmd_req, cmd_op and cmd_wdata hold steady until cmd_done or cmd_fail.
- R5: Each lock poll starts POLL_WAIT_CYC cycles after the previous command completes. It is op 0 with data 0x2003, followed immediately by op 2.
- R6: A read whose data has bit 1 set counts as lock. Ready rises SETTLE_CYC cycles after that read completes, and while ready is high pll_clk_en is 1 and error is 0.
- R7: After MAX_POLLS reads without bit 1, error rises on the next cycle with err_code 2 and no further command is issued. Error is high exactly when err_code is nonzero.
- R8: cmd_fail on any outstanding command raises error on the next cycle with err_code 1, and no further command is issued.
- R9: Enable low while ready or in error returns the block to idle on the next cycle, clearing ready, error, err_code, cfg_en and pll_clk_en.
- R10: Power-down raises pddq and clears ready, cfg_en and pll_clk_en on the next cycle, from any state; it wins over enable in the same cycle.
- R11: Once pddq is set, enable has no effect until reset: no command is issued and cfg_en stays 0.
- R12: cmd_done or cmd_fail with no command outstanding has no effect on outputs or on the delay timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Request bring-up (level) |
| power_down | input | 1 | Request permanent low-power state |
| cmd_done | input | 1 | Command master: outstanding command completed |
| cmd_fail | input | 1 | Command master: outstanding command failed |
| cmd_rdata | input | 16 | Read data, valid with cmd_done on a read |
| cmd_req | output | 1 | Command outstanding |
| cmd_op | output | 2 | Command kind: 0 address, 1 write, 2 read |
| cmd_wdata | output | 16 | Address or write data |
| cfg_en | output | 1 | Apply static PHY configuration |
| pll_clk_en | output | 1 | PLL clock enable |
| pddq | output | 1 | PHY low-power test bit |
| ready | output | 1 | PHY locked and settled |
| error | output | 1 | Sequence aborted |
| err_code | output | 2 | 0 none, 1 command failure, 2 lock timeout |

## Verification
A power-down request can arrive in the same cycle as an enable from idle, or as a command completion, a lock read or the final failed poll. Power-down must win in every case, leaving pddq set with no ready, no error and no later command. The bench drives power-down together with enable in idle, during a poll wait while a command is outstanding, and after ready. It then holds enable high for many cycles and judges the ports: pddq stays high, cfg_en stays low and cmd_req never rises.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CFG, ST_PREWAIT, ST_RST_ADDR, ST_RST_WR,
    ST_POLL_WAIT, ST_POLL_ADDR, ST_POLL_RD, ST_SETTLE,
    ST_READY, ST_FAULT, ST_DOWN
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } cr_op_t;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_HANDSHAKE = 2'd1,
    ERR_LOCK      = 2'd2
  } err_code_t;

  localparam logic [15:0] REG_CLK_RESET = 16'h7F3F;
  localparam logic [15:0] REG_LANE_STAT = 16'h2003;
  localparam logic [15:0] VAL_PHY_RESET = 16'h0001;
  localparam int unsigned LOCK_BIT      = 1;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic lock_reported(logic [15:0] rd);
    return rd[LOCK_BIT];
  endfunction

  function automatic logic is_cmd_state(seq_state_t s);
    return (s == ST_RST_ADDR) || (s == ST_RST_WR) ||
           (s == ST_POLL_ADDR) || (s == ST_POLL_RD);
  endfunction

  function automatic cr_op_t cmd_kind(seq_state_t s);
    case (s)
      ST_RST_ADDR, ST_POLL_ADDR: return OP_ADDR;
      ST_RST_WR:                 return OP_WRITE;
      ST_POLL_RD:                return OP_READ;
      default:                   return OP_NONE;
    endcase
  endfunction

  function automatic logic [15:0] cmd_payload(seq_state_t s);
    case (s)
      ST_RST_ADDR:  return REG_CLK_RESET;
      ST_RST_WR:    return VAL_PHY_RESET;
      ST_POLL_ADDR: return REG_LANE_STAT;
      default:      return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/phy_bringup_timer.sv
module phy_bringup_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/phy_bringup_tries.sv
module phy_bringup_tries #(
  parameter int unsigned MAX_TRIES = 10,
  localparam int unsigned CW = $clog2(MAX_TRIES) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/phy_bringup_cmd.sv
module phy_bringup_cmd
  import phy_bringup_pkg::*;
(
  input  seq_state_t  st,
  output logic        req,
  output logic [1:0]  op,
  output logic [15:0] wdata
);
  always_comb begin
    req   = is_cmd_state(st);
    op    = cmd_kind(st);
    wdata = cmd_payload(st);
  end
endmodule

// File: rtl/phy_pll_bringup.sv
module phy_pll_bringup
  import phy_bringup_pkg::*;
#(
  parameter int unsigned PRE_WAIT_CYC  = 7500,
  parameter int unsigned POLL_WAIT_CYC = 7500,
  parameter int unsigned SETTLE_CYC    = 75000,
  parameter int unsigned MAX_POLLS     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        power_down,
  input  logic        cmd_done,
  input  logic        cmd_fail,
  input  logic [15:0] cmd_rdata,
  output logic        cmd_req,
  output logic [1:0]  cmd_op,
  output logic [15:0] cmd_wdata,
  output logic        cfg_en,
  output logic        pll_clk_en,
  output logic        pddq,
  output logic        ready,
  output logic        error,
  output logic [1:0]  err_code
);
  localparam int unsigned LONGEST = max3(PRE_WAIT_CYC, POLL_WAIT_CYC, SETTLE_CYC);
  localparam int unsigned TW      = $clog2(LONGEST) + 1;

  seq_state_t st, nxt;
  err_code_t  err_q, fault_code;
  logic       cfg_q, pll_q, pddq_q;

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          tries_clr, tries_bump, tries_last;

  // named events for the checker
  logic hs_fault, rd_ok, lock_hit, poll_giveup;

  phy_bringup_cmd u_cmd (
    .st    (st),
    .req   (cmd_req),
    .op    (cmd_op),
    .wdata (cmd_wdata)
  );

  phy_bringup_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  phy_bringup_tries #(.MAX_TRIES(MAX_POLLS)) u_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tries_clr),
    .bump  (tries_bump),
    .last  (tries_last)
  );

  assign hs_fault    = cmd_req & cmd_fail;
  assign rd_ok       = (st == ST_POLL_RD) & cmd_done & ~cmd_fail;
  assign lock_hit    = rd_ok &  lock_reported(cmd_rdata);
  assign poll_giveup = rd_ok & ~lock_reported(cmd_rdata) & tries_last;

  always_comb begin
    nxt        = st;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    tries_clr  = 1'b0;
    tries_bump = 1'b0;
    fault_code = ERR_NONE;
    if (power_down) begin
      nxt = ST_DOWN;
    end else begin
      case (st)
        ST_IDLE: if (enable) nxt = ST_CFG;
        ST_CFG: begin
          nxt      = ST_PREWAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(PRE_WAIT_CYC - 1);
        end
        ST_PREWAIT: if (tmr_expired) nxt = ST_RST_ADDR;
        ST_RST_ADDR: begin
          if (hs_fault) begin
            nxt = ST_FAULT; fault_code = ERR_HANDSHAKE;
          end else if (cmd_done) nxt = ST_RST_WR;
        end
        ST_RST_WR: begin
          if (hs_fault) begin
            nxt = ST_FAULT; fault_code = ERR_HANDSHAKE;
          end else if (cmd_done) begin
            nxt       = ST_POLL_WAIT;
            tmr_load  = 1'b1;
            tmr_val   = TW'(POLL_WAIT_CYC - 1);
            tries_clr = 1'b1;
          end
        end
        ST_POLL_WAIT: if (tmr_expired) nxt = ST_POLL_ADDR;
        ST_POLL_ADDR: begin
          if (hs_fault) begin
            nxt = ST_FAULT; fault_code = ERR_HANDSHAKE;
          end else if (cmd_done) nxt = ST_POLL_RD;
        end
        ST_POLL_RD: begin
          if (hs_fault) begin
            nxt = ST_FAULT; fault_code = ERR_HANDSHAKE;
          end else if (lock_hit) begin
            nxt      = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
          end else if (poll_giveup) begin
            nxt = ST_FAULT; fault_code = ERR_LOCK;
          end else if (rd_ok) begin
            nxt        = ST_POLL_WAIT;
            tmr_load   = 1'b1;
            tmr_val    = TW'(POLL_WAIT_CYC - 1);
            tries_bump = 1'b1;
          end
        end
        ST_SETTLE: if (tmr_expired) nxt = ST_READY;
        ST_READY:  if (!enable) nxt = ST_IDLE;
        ST_FAULT:  if (!enable) nxt = ST_IDLE;
        ST_DOWN:   nxt = ST_DOWN;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cfg_q  <= 1'b0;
      pll_q  <= 1'b0;
      pddq_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      st <= nxt;
      if (nxt != st) begin
        case (nxt)
          ST_CFG:     cfg_q <= 1'b1;
          ST_PREWAIT: pll_q <= 1'b1;
          ST_IDLE: begin
            cfg_q <= 1'b0; pll_q <= 1'b0; err_q <= ERR_NONE;
          end
          ST_FAULT: begin
            cfg_q <= 1'b0; pll_q <= 1'b0; err_q <= fault_code;
          end
          ST_DOWN: begin
            cfg_q <= 1'b0; pll_q <= 1'b0; pddq_q <= 1'b1; err_q <= ERR_NONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_en     = cfg_q;
  assign pll_clk_en = pll_q;
  assign pddq       = pddq_q;
  assign ready      = (st == ST_READY);
  assign error      = (st == ST_FAULT);
  assign err_code   = err_q;
endmodule

// File: rtl/phy_pll_bringup_chk.sv
module phy_pll_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        power_down,
  input logic        cmd_done,
  input logic        cmd_fail,
  input logic        cmd_req,
  input logic [1:0]  cmd_op,
  input logic [15:0] cmd_wdata,
  input logic        cfg_en,
  input logic        pll_clk_en,
  input logic        pddq,
  input logic        ready,
  input logic        error,
  input logic [1:0]  err_code,
  input logic        hs_fault,
  input logic        lock_hit,
  input logic        poll_giveup
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done && !cmd_fail && !power_down)
      |=> (cmd_req && $stable(cmd_op) && $stable(cmd_wdata)));

  p_clk_after_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_clk_en |-> cfg_en);

  p_hs_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fault && !power_down) |=> (error && err_code == 2'd1 && !cmd_req));

  p_giveup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_giveup && !power_down) |=> (error && err_code == 2'd2 && !cmd_req));

  p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error == (err_code != 2'd0));

  p_lock_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && !power_down) |=> (!ready && !cmd_req && !error));

  p_ready_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pll_clk_en && !error));

  p_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (pddq && !ready && !pll_clk_en && !cfg_en));

  p_down_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pddq |=> (pddq && !cfg_en && !cmd_req && !ready));
endmodule

bind phy_pll_bringup phy_pll_bringup_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .power_down  (power_down),
  .cmd_done    (cmd_done),
  .cmd_fail    (cmd_fail),
  .cmd_req     (cmd_req),
  .cmd_op      (cmd_op),
  .cmd_wdata   (cmd_wdata),
  .cfg_en      (cfg_en),
  .pll_clk_en  (pll_clk_en),
  .pddq        (pddq),
  .ready       (ready),
  .error       (error),
  .err_code    (err_code),
  .hs_fault    (hs_fault),
  .lock_hit    (lock_hit),
  .poll_giveup (poll_giveup)
);

// File: tb/phy_pll_bringup_test.sv
module phy_pll_bringup_test;
  localparam int PRE = 5, POLLW = 4, SETTLE = 7, MAXP = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, power_down = 1'b0;
  logic cmd_done = 1'b0, cmd_fail = 1'b0;
  logic [15:0] cmd_rdata = '0;
  logic cmd_req, cfg_en, pll_clk_en, pddq, ready, error;
  logic [1:0] cmd_op, err_code;
  logic [15:0] cmd_wdata;

  phy_pll_bringup #(.PRE_WAIT_CYC(PRE), .POLL_WAIT_CYC(POLLW),
                    .SETTLE_CYC(SETTLE), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .power_down(power_down),
    .cmd_done(cmd_done), .cmd_fail(cmd_fail), .cmd_rdata(cmd_rdata),
    .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cfg_en(cfg_en), .pll_clk_en(pll_clk_en), .pddq(pddq),
    .ready(ready), .error(error), .err_code(err_code));

  int checks = 0, errors = 0, negc = 0;
  bit finished = 0;

  // responder state
  int lock_after = 0, fail_at = 99, ncmd = 0, nreads = 0;
  int lat = 1, lat_cnt = 0;
  bit stray = 0, unstable = 0;
  logic [1:0]  log_op  [64];
  logic [15:0] log_dat [64];
  int log_seen [64];
  int log_done [64];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_op(int idx);
    if (idx == 1) return 1;
    if (idx >= 2 && idx % 2 == 1) return 2;
    return 0;
  endfunction

  function automatic int exp_dat(int idx);
    if (idx == 0) return 'h7F3F;
    if (idx == 1) return 'h0001;
    return 'h2003;
  endfunction

  function automatic int exp_gap(int idx);
    if (idx >= 2 && idx % 2 == 0) return POLLW + 1;
    return 1;
  endfunction

  // command master model
  initial forever begin
    @(negedge clk);
    negc++;
    cmd_done = 1'b0; cmd_fail = 1'b0;
    cmd_rdata = 16'($urandom) & 16'hFFFD;
    if (stray) begin
      cmd_done = 1'b1; stray = 0;
    end else if (rst_n && cmd_req) begin
      if (lat_cnt == 0 && ncmd < 64) begin
        log_seen[ncmd] = negc; log_op[ncmd] = cmd_op; log_dat[ncmd] = cmd_wdata;
      end else if (ncmd < 64 && (cmd_op != log_op[ncmd] || cmd_wdata != log_dat[ncmd])) begin
        unstable = 1;
      end
      lat_cnt++;
      if (lat_cnt >= lat) begin
        if (ncmd == fail_at) cmd_fail = 1'b1; else cmd_done = 1'b1;
        if (cmd_op == 2'd2) begin
          nreads++;
          if (lock_after != 0 && nreads >= lock_after) cmd_rdata = cmd_rdata | 16'h0002;
        end
        if (ncmd < 64) log_done[ncmd] = negc;
        ncmd++; lat_cnt = 0; lat = 1 + int'($urandom % 3);
      end
    end else lat_cnt = 0;
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; enable = 1'b0; power_down = 1'b0;
    tick(2);
    rst_n = 1'b1;
    ncmd = 0; nreads = 0; lat_cnt = 0; unstable = 0; fail_at = 99;
    tick(1);
  endtask

  task automatic run_bringup(int la, int fa, bit stray_pre);
    int k, pll_rise, t_end, exp_n, last;
    do_reset();
    lock_after = la; fail_at = fa;
    enable = 1'b1; k = negc;
    tick(1);
    check(cfg_en && !pll_clk_en, "R2", "cfg first", {cfg_en, pll_clk_en}, 2'b10);
    tick(1);
    check(pll_clk_en, "R2", "pll next cycle", pll_clk_en, 1);
    pll_rise = negc;
    if (stray_pre) stray = 1;
    t_end = -1;
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      if (ready || error) begin t_end = negc; break; end
    end
    check(t_end >= 0, "R6", "sequence finished", t_end, 0);
    if (fa < 99) exp_n = fa + 1;
    else if (la == 0) exp_n = 2 + 2 * MAXP;
    else exp_n = 2 + 2 * la;
    check(ncmd == exp_n, (fa < 99) ? "R8" : (la == 0 ? "R7" : "R5"), "command count", ncmd, exp_n);
    check(!unstable, "R4", "request held stable", unstable, 0);
    for (int i = 0; i < ncmd && i < 64; i++) begin
      check(log_op[i] == 2'(exp_op(i)), (i < 2) ? "R3" : "R5", "op", log_op[i], exp_op(i));
      if (exp_op(i) != 2)
        check(log_dat[i] == 16'(exp_dat(i)), (i < 2) ? "R3" : "R5", "data", log_dat[i], exp_dat(i));
      if (i == 0)
        check(log_seen[0] == pll_rise + PRE, stray_pre ? "R12" : "R3", "first cmd time",
              log_seen[0], pll_rise + PRE);
      else
        check(log_seen[i] == log_done[i-1] + exp_gap(i), (i < 2) ? "R3" : "R5", "cmd time",
              log_seen[i], log_done[i-1] + exp_gap(i));
    end
    last = log_done[(ncmd > 0) ? ncmd - 1 : 0];
    if (fa < 99) begin
      check(error && err_code == 2'd1, "R8", "handshake error code", err_code, 1);
      check(t_end == last + 1, "R8", "error time", t_end, last + 1);
    end else if (la == 0) begin
      check(error && err_code == 2'd2, "R7", "lock timeout code", err_code, 2);
      check(t_end == last + 1, "R7", "error time", t_end, last + 1);
    end else begin
      check(ready && !error && pll_clk_en, "R6", "ready", ready, 1);
      check(t_end == last + SETTLE + 1, "R6", "ready time", t_end, last + SETTLE + 1);
    end
    tick(10);
    check(!cmd_req && ncmd == exp_n, "R7", "no command after end", ncmd, exp_n);
    enable = 1'b0;
    tick(1);
    check(!ready && !error && err_code == 0 && !cfg_en && !pll_clk_en, "R9", "back to idle",
          {ready, error, err_code, cfg_en, pll_clk_en}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    check({ready, error, err_code, cfg_en, pll_clk_en, pddq, cmd_req} == 0, "R1", "reset outputs",
          {ready, error, err_code, cfg_en, pll_clk_en, pddq, cmd_req}, 0);
    // R12 stray completion in idle
    stray = 1; tick(3);
    check(!cmd_req && !error && !cfg_en, "R12", "stray done in idle", {cmd_req, error, cfg_en}, 0);

    run_bringup(1, 99, 0);
    run_bringup(MAXP, 99, 0);
    run_bringup(0, 99, 0);
    run_bringup(3, 99, 1);
    run_bringup(2, 0, 0);
    run_bringup(2, 1, 0);
    for (int r = 0; r < 4; r++) run_bringup(1 + int'($urandom % MAXP), 99, 0);
    for (int r = 0; r < 3; r++) run_bringup(4, 2 + int'($urandom % 8), 0);

    // R10 power-down wins over enable in the same cycle
    do_reset();
    enable = 1'b1; power_down = 1'b1;
    tick(1);
    power_down = 1'b0;
    check(pddq && !cfg_en && !pll_clk_en, "R10", "pd beats enable", {pddq, cfg_en, pll_clk_en}, 3'b100);
    for (int i = 0; i < 6; i++) begin enable = ~enable; tick(3); end
    enable = 1'b1; tick(20);
    check(pddq && !cfg_en && !cmd_req && ncmd == 0, "R11", "enable ignored after pd",
          {pddq, cfg_en, cmd_req}, 3'b100);

    // R10 power-down from ready
    do_reset();
    lock_after = 2; enable = 1'b1;
    for (int i = 0; i < 3000 && !ready; i++) tick(1);
    power_down = 1'b1; tick(1); power_down = 1'b0;
    check(pddq && !ready && !pll_clk_en, "R10", "pd from ready", {pddq, ready, pll_clk_en}, 3'b100);
    tick(30);
    check(pddq && !ready && !cfg_en, "R11", "stays down with enable high", {pddq, ready, cfg_en}, 3'b100);

    // R10/R11 power-down mid-poll with a command outstanding
    do_reset();
    lock_after = 0; enable = 1'b1;
    for (int i = 0; i < 3000 && !(ncmd >= 3 && cmd_req); i++) tick(1);
    power_down = 1'b1; tick(1); power_down = 1'b0;
    begin
      int n0;
      n0 = ncmd;
      check(pddq && !cmd_req, "R10", "pd drops request", {pddq, cmd_req}, 2'b10);
      tick(60);
      check(ncmd == n0 && !cmd_req && !error, "R11", "no command after pd", ncmd, n0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule